// File: doc/BRIEF.md
# Chip-Counted Despreading Correlator

This block despreads a stream of 12-bit signed samples against the spreading code that is current at each instant. Every sample that arrives with its valid strobe is sign-extended to 32 bits. It is added to a running sum when the current chip is 0 and subtracted when the chip is 1. Samples without the strobe leave the sum untouched.

The integration window is measured in chips, not in samples. An external chip-advance pulse steps an internal chip counter. On the 1023rd advance of a window the block presents the sum, including the sample taken in that same cycle, on its correlation output, one clock later. It raises a result strobe for exactly one cycle and starts the next window from zero. A synchronisation input discards the window in progress without producing a result. It is used after the code generator and the sample-rate phase accumulator have been aligned.

Top module: `despread_correlator`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `corr_o` is 0 and `corr_valid_o` is 0.
- R2: A sample accepted with `chip_i` = 0 adds its value to the running sum, reading `smp_i` as 12-bit two's complement (so 12'h800 is -2048 and 12'h7FF is +2047).
- R3: A sample accepted with `chip_i` = 1 subtracts its two's complement value from the running sum.
- R4: A sample is taken only in a cycle with `smp_valid_i` high. In other cycles the value on `smp_i` has no effect on any later result.
- R5: In the cycle after the one that carries the 1023rd `chip_adv_i` pulse of a window, `corr_valid_o` is high and `corr_o` equals the running sum (modulo 2^32), including any sample accepted in that advancing cycle.
- R6: `corr_valid_o` is high for one cycle per window. The running sum and chip count restart from zero, so each result covers only its own window.
- R7: A cycle with `sync_i` high clears the running sum and the chip count and raises no result. The sample and any advance in that cycle are discarded.
- R8: `corr_o` keeps its last result until the next result is presented.
- R9: When a sample and a chip advance fall in the same cycle, the sample is weighted by the `chip_i` value present in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Discard the current window and restart the count |
| smp_valid_i | input | 1 | Sample on `smp_i` is valid this cycle |
| smp_i | input | 12 | Signed two's complement sample |
| chip_i | input | 1 | Current code chip: 0 adds, 1 subtracts |
| chip_adv_i | input | 1 | One-cycle pulse stepping to the next chip |
| corr_o | output | 32 | Last correlation result |
| corr_valid_o | output | 1 | One-cycle strobe marking a new result |

## Verification
The running sum and the chip count are visible only through the results. A corrupted sum therefore shows up as a wrong `corr_o` at the end of the window it falls in, at most 1023 chips later. A chip count that is off by even one shows up as a result strobe that comes early or late. Because of this, every window is checked by comparing both outputs against a behavioural model on every clock, so a wrong value or a strobe in the wrong cycle is caught in the cycle it appears. The windows mix all-add, all-subtract, mixed chips, gapped samples, extreme sample values and syncs, including a sync that lands on the final advance.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
   localparam int DSC_SAMPLE_W = 12;
   localparam int DSC_SUM_W    = 32;
   localparam int DSC_CHIPS    = 1023;

   typedef enum logic {
      CHIP_ADD = 1'b0,
      CHIP_SUB = 1'b1
   } chip_pol_e;
endpackage

// File: rtl/dsc_weight.sv
// Weights one sample by the current chip: sign-extend, then pass or negate.
module dsc_weight
   import dsc_pkg::*;
#(
   parameter int SAMPLE_W = DSC_SAMPLE_W,
   parameter int SUM_W    = DSC_SUM_W
) (
   input  logic                smp_valid,
   input  logic [SAMPLE_W-1:0] smp,
   input  logic                chip,
   output logic [SUM_W-1:0]    term
);
   localparam int EXT_W = SUM_W - SAMPLE_W;

   logic [SUM_W-1:0] ext;

   generate
      if (SAMPLE_W > SUM_W) begin : g_bad_width
         $error("dsc_weight: SAMPLE_W must not exceed SUM_W");
      end
      if (SAMPLE_W < 2) begin : g_bad_sample
         $error("dsc_weight: SAMPLE_W must be at least 2");
      end
      if (EXT_W > 0) begin : g_extend
         assign ext = {{EXT_W{smp[SAMPLE_W-1]}}, smp};
      end else begin : g_direct
         assign ext = smp[SUM_W-1:0];
      end
   endgenerate

   chip_pol_e pol;
   assign pol = chip_pol_e'(chip);

   always_comb begin
      if (!smp_valid) begin
         term = '0;
      end else if (pol == CHIP_SUB) begin
         term = (~ext) + SUM_W'(1);
      end else begin
         term = ext;
      end
   end
endmodule

// File: rtl/dsc_chip_counter.sv
// Counts chip-advance pulses and flags the one that closes a window.
module dsc_chip_counter
   import dsc_pkg::*;
#(
   parameter int CHIPS = DSC_CHIPS
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync,
   input  logic adv,
   output logic window_end
);
   localparam int CNT_W = (CHIPS > 1) ? $clog2(CHIPS) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CHIPS - 1);

   generate
      if (CHIPS < 2) begin : g_bad_chips
         $error("dsc_chip_counter: CHIPS must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;

   assign window_end = adv && !sync && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (sync || window_end) begin
         cnt <= '0;
      end else if (adv) begin
         cnt <= cnt + CNT_W'(1);
      end
   end
endmodule

// File: rtl/dsc_accum.sv
// Running sum with dump-and-clear and a held result register.
module dsc_accum
   import dsc_pkg::*;
#(
   parameter int SUM_W = DSC_SUM_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync,
   input  logic             dump,
   input  logic [SUM_W-1:0] term,
   output logic [SUM_W-1:0] result,
   output logic             result_valid
);
   logic [SUM_W-1:0] sum;
   logic [SUM_W-1:0] sum_next;

   assign sum_next = sum + term;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum          <= '0;
         result       <= '0;
         result_valid <= 1'b0;
      end else begin
         result_valid <= 1'b0;
         if (sync) begin
            sum <= '0;
         end else if (dump) begin
            sum          <= '0;
            result       <= sum_next;
            result_valid <= 1'b1;
         end else begin
            sum <= sum_next;
         end
      end
   end
endmodule

// File: rtl/despread_correlator.sv
module despread_correlator
   import dsc_pkg::*;
#(
   parameter int SAMPLE_W = DSC_SAMPLE_W,
   parameter int SUM_W    = DSC_SUM_W,
   parameter int CHIPS    = DSC_CHIPS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sync_i,
   input  logic                smp_valid_i,
   input  logic [SAMPLE_W-1:0] smp_i,
   input  logic                chip_i,
   input  logic                chip_adv_i,
   output logic [SUM_W-1:0]    corr_o,
   output logic                corr_valid_o
);
   logic [SUM_W-1:0] term;
   logic             window_end;

   dsc_weight #(
      .SAMPLE_W (SAMPLE_W),
      .SUM_W    (SUM_W)
   ) u_weight (
      .smp_valid (smp_valid_i),
      .smp       (smp_i),
      .chip      (chip_i),
      .term      (term)
   );

   dsc_chip_counter #(
      .CHIPS (CHIPS)
   ) u_count (
      .clk        (clk),
      .rst_n      (rst_n),
      .sync       (sync_i),
      .adv        (chip_adv_i),
      .window_end (window_end)
   );

   dsc_accum #(
      .SUM_W (SUM_W)
   ) u_accum (
      .clk          (clk),
      .rst_n        (rst_n),
      .sync         (sync_i),
      .dump         (window_end),
      .term         (term),
      .result       (corr_o),
      .result_valid (corr_valid_o)
   );
endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
   parameter int SUM_W = 32,
   parameter int CHIPS = 1023
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sync_i,
   input logic             chip_adv_i,
   input logic [SUM_W-1:0] corr_o,
   input logic             corr_valid_o
);
   localparam int CW = $clog2(CHIPS + 1);

   // Independent count of advances seen since the window started.
   logic [CW-1:0] seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen <= '0;
      end else if (sync_i) begin
         seen <= '0;
      end else if (corr_valid_o) begin
         seen <= chip_adv_i ? CW'(1) : '0;
      end else if (chip_adv_i) begin
         seen <= seen + CW'(1);
      end
   end

   assert_dump_on_last_chip_R5: assert property (@(posedge clk) disable iff (!rst_n)
      corr_valid_o == (seen == CW'(CHIPS)));

   assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      corr_valid_o |=> !corr_valid_o);

   assert_sync_no_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sync_i |=> !corr_valid_o);

   assert_result_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !corr_valid_o |-> $stable(corr_o));
endmodule

bind despread_correlator dsc_checker #(
   .SUM_W (SUM_W),
   .CHIPS (CHIPS)
) u_dsc_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .sync_i       (sync_i),
   .chip_adv_i   (chip_adv_i),
   .corr_o       (corr_o),
   .corr_valid_o (corr_valid_o)
);

// File: tb/despread_correlator_test.sv
`timescale 1ns/1ps
module despread_correlator_test;
   localparam int CHIPS = 1023;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sync_i = 1'b0;
   logic        smp_valid_i = 1'b0;
   logic [11:0] smp_i = '0;
   logic        chip_i = 1'b0;
   logic        chip_adv_i = 1'b0;
   logic [31:0] corr_o;
   logic        corr_valid_o;

   always #10 clk = ~clk;

   despread_correlator uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .sync_i       (sync_i),
      .smp_valid_i  (smp_valid_i),
      .smp_i        (smp_i),
      .chip_i       (chip_i),
      .chip_adv_i   (chip_adv_i),
      .corr_o       (corr_o),
      .corr_valid_o (corr_valid_o)
   );

   int    compared = 0;
   int    mismatched = 0;
   string cur_req = "R1";
   bit    finished = 0;

   // Behavioural reference model.
   longint      m_sum = 0;
   int          m_cnt = 0;
   logic [31:0] exp_corr = '0;
   logic        exp_valid = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_sum = 0; m_cnt = 0; exp_corr = '0; exp_valid = 1'b0;
      end else begin
         exp_valid = 1'b0;
         if (sync_i) begin
            m_sum = 0; m_cnt = 0;
         end else begin
            if (smp_valid_i) begin
               if (chip_i) m_sum = m_sum - longint'($signed(smp_i));
               else        m_sum = m_sum + longint'($signed(smp_i));
            end
            if (chip_adv_i) begin
               m_cnt = m_cnt + 1;
               if (m_cnt == CHIPS) begin
                  exp_corr  = m_sum[31:0];
                  exp_valid = 1'b1;
                  m_sum = 0; m_cnt = 0;
               end
            end
         end
      end
   end

   // Compare on every clock, away from the active edge.
   always @(negedge clk) begin
      if (!finished) begin
         compared++;
         if (corr_valid_o !== exp_valid) begin
            mismatched++;
            $display("FAIL %s: corr_valid_o actual %b expected %b at %0t",
                     cur_req, corr_valid_o, exp_valid, $time);
         end
         compared++;
         if (corr_o !== exp_corr) begin
            mismatched++;
            $display("FAIL %s: corr_o actual %h expected %h at %0t",
                     cur_req, corr_o, exp_corr, $time);
         end
      end
   end

   int unsigned rng = 32'h1234_5678;
   function automatic int unsigned next_rand();
      rng = rng * 32'd1103515245 + 32'd12345;
      return rng >> 8;
   endfunction

   task automatic drive(input bit v, input logic [11:0] s, input bit c,
                        input bit a, input bit y);
      @(negedge clk);
      #1;
      smp_valid_i = v; smp_i = s; chip_i = c; chip_adv_i = a; sync_i = y;
   endtask

   // chip_mode: 0 all add, 1 all subtract, 2 random
   // val_mode: 0 always valid, 1 random gaps
   // smp_mode: 0 random, 1 extremes alternating
   task automatic window(input int n_adv, input int period, input int chip_mode,
                         input int val_mode, input int smp_mode);
      int advs = 0;
      int cyc = 0;
      while (advs < n_adv) begin
         bit a = ((cyc % period) == period - 1);
         bit v = (val_mode == 0) ? 1'b1 : bit'(next_rand() & 1);
         bit c = (chip_mode == 2) ? bit'((next_rand() >> 3) & 1) : bit'(chip_mode);
         logic [11:0] s = (smp_mode == 1) ? ((cyc & 1) ? 12'h7FF : 12'h800)
                                          : 12'(next_rand());
         drive(v, s, c, a, 1'b0);
         if (a) advs++;
         cyc++;
      end
      repeat (3) drive(1'b0, 12'(next_rand()), 1'b0, 1'b0, 1'b0);
   endtask

   initial begin
      cur_req = "R1";
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      repeat (2) drive(1'b0, '0, 1'b0, 1'b0, 1'b0);

      cur_req = "R2";           // add only, sample every cycle, R9 overlap
      window(CHIPS, 1, 0, 0, 0);
      cur_req = "R3";           // subtract only, extreme values
      window(CHIPS, 2, 1, 0, 1);
      cur_req = "R4";           // gapped samples with garbage on smp_i
      window(CHIPS, 2, 2, 1, 0);
      cur_req = "R9";           // mixed chips, advance every cycle
      window(CHIPS, 1, 2, 0, 1);
      cur_req = "R6";           // back-to-back windows start from zero
      window(CHIPS, 1, 0, 0, 1);
      window(CHIPS, 1, 2, 0, 0);

      cur_req = "R7";           // sync mid-window, then a full window
      window(500, 2, 2, 0, 0);
      drive(1'b1, 12'h3FF, 1'b0, 1'b1, 1'b1);
      window(CHIPS, 2, 2, 1, 0);
      // sync landing on the closing advance: no result
      window(CHIPS - 1, 1, 0, 0, 0);
      drive(1'b1, 12'h123, 1'b0, 1'b1, 1'b1);
      cur_req = "R8";           // output holds while idle
      repeat (20) drive(1'b1, 12'(next_rand()), 1'b0, 1'b0, 1'b0);
      cur_req = "R7";
      window(CHIPS, 1, 2, 0, 1);
      cur_req = "R5";
      window(CHIPS, 3, 2, 1, 1);

      repeat (3) drive(1'b0, '0, 1'b0, 1'b0, 1'b0);
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!finished) begin
         finished = 1;
         compared++;
         mismatched++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule